// File: doc/BRIEF.md
# UART Receive Line Status Tracker

This block keeps the receive-side state of a 16450/16550-style UART and assembles the 8-bit line status byte that the host reads. In single-byte mode a received character lands in a one-deep holding register. In FIFO mode it is appended to a 16-entry receive queue. Each stored character carries its data byte and three error flags: parity error, missing stop bit and break.

The host pops received data with a data-read strobe and reads the status byte with a status-read strobe. Reading the status acknowledges the error and overrun indications. Two transmit-side inputs (holding buffer empty, shifter empty) come from the transmitter and pass into the two transmit bits of the byte.

In FIFO mode the error bits describe only the character at the head of the queue. A separate summary bit stays up while any errored character is still queued, and a status read clears it only once none remain.

Top module: `uart_line_status`

## Requirements
- R1: The status byte `status` carries, from bit 7 down to bit 0: FIFO error summary, transmitter fully empty, transmit buffer empty, break, missing stop bit, parity error, overrun, data ready.
- R2: In single-byte mode (`fifo_mode` = 0) bit 7 reads 0 at all times.
- R3: In FIFO mode bit 7 becomes 1 in the cycle after an errored character (any of the three flags set) is queued, and stays 1 while any errored character is queued. A status read clears it in the following cycle only if no errored character was queued when the read happened.
- R4: A status read clears bits 4..2 in the following cycle, unless a character arrives or is popped in that same cycle. In single-byte mode these bits are sticky: each is set by an arriving character with that flag.
- R5: In FIFO mode bits 4..2 show the break, missing-stop and parity flags of the character at the queue head. After a pop they show the new head's flags, whether or not an earlier status read masked the old head. They read 0 when the queue is empty.
- R6: Overrun (bit 1) is set when a character arrives while the holding register is occupied and not being read in the same cycle (single-byte mode), or while the queue holds 16 entries and is not being popped (FIFO mode). A status read clears it unless a new overrun occurs in the same cycle. The character that arrives at a full queue is dropped, and the 16 queued characters are kept in order.
- R7: Data ready (bit 0) is 1 while the holding register (single-byte mode) or the queue (FIFO mode) holds unread data, and 0 otherwise.
- R8: Bit 5 equals `tx_buf_empty`. Bit 6 is 1 only when `tx_buf_empty` and `tx_shift_empty` are both 1.
- R9: In single-byte mode a new character overwrites the holding register. If a data read and an arrival happen in the same cycle, the new character is held and no overrun is raised.
- R10: A change of `fifo_mode` empties the holding register and the queue, and clears the error flags, the overrun bit and the summary bit at the next clock edge. A character arriving in that cycle is dropped.
- R11: After reset, with both transmit-empty inputs at 1, the status byte is 0x60.
- R12: `rd_data` presents the held character (single-byte mode) or the queue head (FIFO mode) while data ready is 1. A data read consumes that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 0 = single-byte holding register, 1 = 16-entry receive queue |
| rx_valid | input | 1 | One-cycle strobe: a received character is presented |
| rx_data | input | 8 | Received data byte |
| rx_parity_err | input | 1 | Received character has a wrong parity bit |
| rx_frame_err | input | 1 | Received character has no stop bit |
| rx_break | input | 1 | Line stayed spacing for a whole character time |
| data_rd | input | 1 | Host reads (consumes) the received data |
| status_rd | input | 1 | Host reads the status byte |
| tx_buf_empty | input | 1 | Transmit holding register or transmit queue is empty |
| tx_shift_empty | input | 1 | Transmit shifter is empty |
| rd_data | output | 8 | Character available to the host |
| status | output | 8 | Line status byte |

## Verification
Some rules are checked by the assertions on every cycle. These are: bit 7 stays 0 in single-byte mode, bit 7 stays up while errored characters are counted in the queue, a status read with no arrival or pop clears the error bits and overrun, data ready follows an arrival, the queue occupancy never passes its depth, and the fully-empty bit implies an empty shifter. Other behaviour needs the bench's scenarios and its per-cycle reference model. That covers: the summary bit lingering after the last errored entry is popped until a status read, the head flags coming back after a pop, a full queue dropping a character while keeping the 16 stored bytes in order, an overwrite in single-byte mode, and the flush on a mode change.

// File: rtl/uart_ls_pkg.sv
package uart_ls_pkg;

    localparam int DATA_W = 8;

    // One received character with its error flags
    typedef struct packed {
        logic              brk;
        logic              frame_err;
        logic              parity_err;
        logic [DATA_W-1:0] data;
    } rx_char_t;

    // Status byte layout, bit 7 first
    typedef struct packed {
        logic fifo_err;
        logic tx_all_empty;
        logic tx_buf_empty;
        logic brk;
        logic frame_err;
        logic parity_err;
        logic overrun;
        logic ready;
    } line_status_t;

    function automatic logic char_has_err(input rx_char_t c);
        return c.brk | c.frame_err | c.parity_err;
    endfunction

endpackage

// File: rtl/uart_ls_fifo.sv
module uart_ls_fifo
    import uart_ls_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  rx_char_t      din,
    output rx_char_t      head,
    output logic [CW-1:0] count
);

    rx_char_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= next_ptr(wr_ptr);
            if (pop)  rd_ptr <= next_ptr(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/uart_ls_errcount.sv
module uart_ls_errcount #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push_err,
    input  logic          pop_err,
    output logic [CW-1:0] err_cnt
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            err_cnt <= '0;
        end else begin
            err_cnt <= err_cnt + CW'(push_err) - CW'(pop_err);
        end
    end

endmodule

// File: rtl/uart_ls_holding.sv
module uart_ls_holding
    import uart_ls_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     load,
    input  logic     unload,
    input  logic     status_rd,
    input  rx_char_t din,
    output rx_char_t held,
    output logic     valid,
    output logic [2:0] sticky      // {brk, frame_err, parity_err}
);

    logic [2:0] new_flags;
    assign new_flags = load ? {din.brk, din.frame_err, din.parity_err} : 3'b000;

    always_ff @(posedge clk) begin
        if (load) begin
            held <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid  <= 1'b0;
            sticky <= 3'b000;
        end else begin
            if (load)        valid <= 1'b1;
            else if (unload) valid <= 1'b0;
            sticky <= (status_rd ? 3'b000 : sticky) | new_flags;
        end
    end

endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
    import uart_ls_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_mode,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_parity_err,
    input  logic              rx_frame_err,
    input  logic              rx_break,
    input  logic              data_rd,
    input  logic              status_rd,
    input  logic              tx_buf_empty,
    input  logic              tx_shift_empty,
    output logic [DATA_W-1:0] rd_data,
    output logic [7:0]        status
);

    rx_char_t     rx_char;
    rx_char_t     fifo_head;
    rx_char_t     held;
    logic         mode_q;
    logic         flush;
    logic [CW-1:0] fifo_count;
    logic [CW-1:0] err_cnt;
    logic         fifo_empty;
    logic         fifo_full;
    logic         fifo_push;
    logic         fifo_pop;
    logic         hold_load;
    logic         hold_unload;
    logic         hold_valid;
    logic [2:0]   hold_sticky;
    logic         head_masked;
    logic         summary;
    logic         overrun;
    logic         ovr_set;
    line_status_t ls;

    assign rx_char = '{brk: rx_break, frame_err: rx_frame_err,
                       parity_err: rx_parity_err, data: rx_data};

    // Mode change detection: one-cycle flush of all receive state
    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= fifo_mode;
    end
    assign flush = (fifo_mode != mode_q);

    assign fifo_empty = (fifo_count == '0);
    assign fifo_full  = (fifo_count == CW'(DEPTH));

    assign fifo_pop  = fifo_mode && !flush && data_rd && !fifo_empty;
    assign fifo_push = fifo_mode && !flush && rx_valid && (!fifo_full || fifo_pop);

    assign hold_load   = !fifo_mode && !flush && rx_valid;
    assign hold_unload = !fifo_mode && data_rd && hold_valid;

    assign ovr_set = !flush && rx_valid &&
                     (fifo_mode ? (fifo_full && !fifo_pop) : (hold_valid && !data_rd));

    uart_ls_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .din   (rx_char),
        .head  (fifo_head),
        .count (fifo_count)
    );

    uart_ls_errcount #(.DEPTH(DEPTH)) u_errcnt (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .push_err (fifo_push && char_has_err(rx_char)),
        .pop_err  (fifo_pop && char_has_err(fifo_head)),
        .err_cnt  (err_cnt)
    );

    uart_ls_holding u_hold (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .load      (hold_load),
        .unload    (hold_unload),
        .status_rd (status_rd),
        .din       (rx_char),
        .held      (held),
        .valid     (hold_valid),
        .sticky    (hold_sticky)
    );

    // Head flags are hidden after a status read until the head changes
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_masked <= 1'b0;
        end else if (fifo_pop) begin
            head_masked <= 1'b0;
        end else if (status_rd && !fifo_empty) begin
            head_masked <= 1'b1;
        end
    end

    // Summary of errored entries anywhere in the queue
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            summary <= 1'b0;
        end else if (fifo_push && char_has_err(rx_char)) begin
            summary <= 1'b1;
        end else if (status_rd && err_cnt == '0) begin
            summary <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            overrun <= 1'b0;
        end else begin
            overrun <= (status_rd ? 1'b0 : overrun) | ovr_set;
        end
    end

    always_comb begin
        ls              = '0;
        ls.fifo_err     = fifo_mode && summary;
        ls.tx_buf_empty = tx_buf_empty;
        ls.tx_all_empty = tx_buf_empty && tx_shift_empty;
        ls.overrun      = overrun;
        if (fifo_mode) begin
            ls.ready = !fifo_empty;
            if (!fifo_empty && !head_masked) begin
                ls.brk        = fifo_head.brk;
                ls.frame_err  = fifo_head.frame_err;
                ls.parity_err = fifo_head.parity_err;
            end
        end else begin
            ls.ready = hold_valid;
            {ls.brk, ls.frame_err, ls.parity_err} = hold_sticky;
        end
    end

    assign status  = ls;
    assign rd_data = fifo_mode ? fifo_head.data : held.data;

endmodule

// File: rtl/uart_line_status_chk.sv
module uart_line_status_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_mode,
    input logic          rx_valid,
    input logic          data_rd,
    input logic          status_rd,
    input logic          tx_shift_empty,
    input logic [7:0]    status,
    input logic [CW-1:0] fifo_count,
    input logic [CW-1:0] err_cnt
);

    logic mode_seen;
    always_ff @(posedge clk) begin
        if (rst) mode_seen <= 1'b0;
        else     mode_seen <= fifo_mode;
    end

    // R2
    a_r2_no_summary_single: assert property (@(posedge clk) disable iff (rst)
        !fifo_mode |-> !status[7]);

    // R3
    a_r3_summary_while_errored: assert property (@(posedge clk) disable iff (rst)
        (fifo_mode && err_cnt != '0) |-> status[7]);

    // R4
    a_r4_flags_cleared: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !rx_valid && !data_rd) |=> (status[4:2] == 3'b000));

    // R6
    a_r6_overrun_cleared: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !rx_valid) |=> !status[1]);

    // R6
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CW'(DEPTH));

    // R7
    a_r7_ready_after_arrival: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && fifo_mode == mode_seen) |=> (status[0] || fifo_mode != $past(fifo_mode)));

    // R8
    a_r8_all_empty_needs_shifter: assert property (@(posedge clk) disable iff (rst)
        status[6] |-> tx_shift_empty);

endmodule

bind uart_line_status uart_line_status_chk #(.DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .fifo_mode      (fifo_mode),
    .rx_valid       (rx_valid),
    .data_rd        (data_rd),
    .status_rd      (status_rd),
    .tx_shift_empty (tx_shift_empty),
    .status         (status),
    .fifo_count     (fifo_count),
    .err_cnt        (err_cnt)
);

// File: tb/uart_line_status_test.sv
module uart_line_status_test;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_mode = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_parity_err = 1'b0;
    logic       rx_frame_err = 1'b0;
    logic       rx_break = 1'b0;
    logic       data_rd = 1'b0;
    logic       status_rd = 1'b0;
    logic       tx_buf_empty = 1'b1;
    logic       tx_shift_empty = 1'b1;
    logic [7:0] rd_data;
    logic [7:0] status;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    uart_line_status #(.DEPTH(DEPTH)) uut (
        .clk            (clk),
        .rst            (rst),
        .fifo_mode      (fifo_mode),
        .rx_valid       (rx_valid),
        .rx_data        (rx_data),
        .rx_parity_err  (rx_parity_err),
        .rx_frame_err   (rx_frame_err),
        .rx_break       (rx_break),
        .data_rd        (data_rd),
        .status_rd      (status_rd),
        .tx_buf_empty   (tx_buf_empty),
        .tx_shift_empty (tx_shift_empty),
        .rd_data        (rd_data),
        .status         (status)
    );

    // ---------------- reference model ----------------
    // entry = {brk, frame, parity, data}
    logic [10:0] m_q[$];
    logic [10:0] m_hold;
    logic        m_hv, m_ovr, m_mask, m_ferr, m_mode;
    logic [2:0]  m_sticky;

    function automatic logic ent_err(input logic [10:0] e);
        return |e[10:8];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_q.delete(); m_hv = 0; m_ovr = 0; m_mask = 0; m_ferr = 0;
            m_sticky = 0; m_mode = 0; m_hold = 0;
        end else if (fifo_mode != m_mode) begin
            m_q.delete(); m_hv = 0; m_ovr = 0; m_mask = 0; m_ferr = 0;
            m_sticky = 0; m_mode = fifo_mode;
        end else if (!fifo_mode) begin
            logic ovs;
            ovs = rx_valid && m_hv && !data_rd;
            if (status_rd) m_sticky = 0;
            if (rx_valid) begin
                m_hold = {rx_break, rx_frame_err, rx_parity_err, rx_data};
                m_hv = 1;
                m_sticky = m_sticky | {rx_break, rx_frame_err, rx_parity_err};
            end else if (data_rd) m_hv = 0;
            if (status_rd) m_ovr = 0;
            if (ovs) m_ovr = 1;
        end else begin
            int nerr;
            logic pop, push, full, ovs;
            logic [10:0] ne;
            nerr = 0;
            foreach (m_q[i]) if (ent_err(m_q[i])) nerr++;
            ne = {rx_break, rx_frame_err, rx_parity_err, rx_data};
            pop  = data_rd && m_q.size() > 0;
            full = (m_q.size() == DEPTH);
            push = rx_valid && (!full || pop);
            ovs  = rx_valid && full && !pop;
            if (pop) m_mask = 0;
            else if (status_rd && m_q.size() > 0) m_mask = 1;
            if (push && ent_err(ne)) m_ferr = 1;
            else if (status_rd && nerr == 0) m_ferr = 0;
            if (pop) void'(m_q.pop_front());
            if (push) m_q.push_back(ne);
            if (status_rd) m_ovr = 0;
            if (ovs) m_ovr = 1;
        end
    end

    function automatic logic [7:0] exp_status();
        logic [7:0] s;
        s = 8'h00;
        s[7] = fifo_mode && m_ferr;
        s[6] = tx_buf_empty && tx_shift_empty;
        s[5] = tx_buf_empty;
        s[1] = m_ovr;
        if (fifo_mode) begin
            s[0] = m_q.size() > 0;
            if (m_q.size() > 0 && !m_mask) s[4:2] = m_q[0][10:8];
        end else begin
            s[0] = m_hv;
            s[4:2] = m_sticky;
        end
        return s;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            logic [7:0] e;
            e = exp_status();
            chk(status[7] == e[7], fifo_mode ? "R3 summary bit" : "R2 summary bit", status, e);
            chk(status[6:5] == e[6:5], "R8 transmit bits", status, e);
            chk(status[4:2] == e[4:2], fifo_mode ? "R5 head flags" : "R4 sticky flags", status, e);
            chk(status[1] == e[1], "R6 overrun", status, e);
            chk(status[0] == e[0], "R7 data ready", status, e);
            if (e[0]) begin
                logic [7:0] ed;
                ed = fifo_mode ? m_q[0][7:0] : m_hold[7:0];
                chk(rd_data == ed, "R12 read data", rd_data, ed);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input logic rv, input logic [7:0] d, input logic [2:0] fl,
                        input logic drd, input logic srd);
        rx_valid = rv; rx_data = d;
        {rx_break, rx_frame_err, rx_parity_err} = fl;
        data_rd = drd; status_rd = srd;
        @(posedge clk); #1;
        rx_valid = 0; data_rd = 0; status_rd = 0;
        {rx_break, rx_frame_err, rx_parity_err} = 3'b000;
    endtask

    task automatic expect_status(input logic [7:0] e, input string tag);
        @(negedge clk);
        chk(status == e, tag, status, e);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        expect_status(8'h60, "R11 reset value");

        // single-byte mode
        step(1, 8'hA5, 3'b001, 0, 0);
        expect_status(8'h65, "R1 parity bit and ready");
        chk(rd_data == 8'hA5, "R12 held byte", rd_data, 8'hA5);
        step(0, 0, 0, 0, 1);
        expect_status(8'h61, "R4 cleared by status read");
        step(1, 8'h3C, 3'b000, 0, 0);
        expect_status(8'h63, "R6 single-byte overrun");
        chk(rd_data == 8'h3C, "R9 overwrite", rd_data, 8'h3C);
        step(0, 0, 0, 0, 1);
        step(1, 8'h11, 3'b000, 1, 0);
        expect_status(8'h61, "R9 read with arrival no overrun");
        chk(rd_data == 8'h11, "R9 new byte held", rd_data, 8'h11);
        step(0, 0, 0, 1, 0);
        expect_status(8'h60, "R7 ready drops");
        step(1, 8'h00, 3'b100, 0, 0);
        expect_status(8'h71, "R2 break in single mode, bit7 low");
        step(0, 0, 0, 1, 1);

        // switch to FIFO mode with a char held
        step(1, 8'h22, 3'b010, 0, 0);
        fifo_mode = 1;
        step(0, 0, 0, 0, 0);
        expect_status(8'h60, "R10 flush on mode change");

        step(1, 8'h41, 3'b000, 0, 0);
        step(1, 8'h42, 3'b010, 0, 0);
        step(1, 8'h43, 3'b000, 0, 0);
        expect_status(8'hE1, "R3 summary set");
        step(0, 0, 0, 0, 1);
        expect_status(8'hE1, "R3 summary kept while errored queued");
        step(0, 0, 0, 1, 0);
        expect_status(8'hE9, "R5 head frame flag");
        chk(rd_data == 8'h42, "R12 head byte", rd_data, 8'h42);
        step(0, 0, 0, 0, 1);
        expect_status(8'hE1, "R4 head flags masked");
        step(0, 0, 0, 1, 0);
        expect_status(8'hE1, "R3 summary lingers after pop");
        step(0, 0, 0, 0, 1);
        expect_status(8'h61, "R3 summary cleared");
        step(0, 0, 0, 1, 0);
        expect_status(8'h60, "R7 FIFO empty");

        // fill and overflow
        for (int i = 0; i < DEPTH; i++) step(1, 8'h80 + 8'(i), 3'b000, 0, 0);
        step(1, 8'hFF, 3'b001, 0, 0);
        expect_status(8'h63, "R6 FIFO overrun, dropped char");
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            chk(rd_data == 8'h80 + 8'(i), "R6 kept contents", rd_data, 8'h80 + 8'(i));
            step(0, 0, 0, 1, 0);
        end
        expect_status(8'h62, "R7 drained");
        step(0, 0, 0, 0, 1);
        expect_status(8'h60, "R6 overrun cleared");

        // transmit inputs
        tx_buf_empty = 0;
        expect_status(8'h00, "R8 buffer busy");
        tx_buf_empty = 1; tx_shift_empty = 0;
        expect_status(8'h20, "R8 shifter busy");
        tx_shift_empty = 1;

        // mode change back with data queued
        step(1, 8'h55, 3'b100, 0, 0);
        step(1, 8'h56, 3'b000, 0, 0);
        fifo_mode = 0;
        step(0, 0, 0, 0, 0);
        expect_status(8'h60, "R10 flush back to single");

        // random traffic in both modes
        for (int n = 0; n < 3000; n++) begin
            if (n % 600 == 599) fifo_mode = ~fifo_mode;
            tx_buf_empty = ($urandom_range(0, 7) != 0);
            tx_shift_empty = ($urandom_range(0, 3) != 0);
            step($urandom_range(0, 2) != 0, 8'($urandom), 3'($urandom_range(0, 7) & {3{$urandom_range(0, 3) == 0}}),
                 $urandom_range(0, 2) == 0, $urandom_range(0, 4) == 0);
        end

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule